// File: doc/BRIEF.md
# Flash command controller

This block is the command front end of an embedded flash array. Software reaches it over a simple 32-bit register bus. The bus has three registers, key, control and status, plus a window onto the flash address space. The control register stays locked after reset. It opens only when two key words arrive in the right order at the key register. Once the block is open, software can select program, sector erase or mass erase, choose the program width and the sector, and then launch the operation.

Each accepted operation becomes a one-cycle request to the flash macro. The macro answers with a busy level. The block folds that busy level into its own status busy flag. Any command that is refused sets one sticky status flag, and software clears the flag by writing 1 to it. A command can be refused for bad ordering, width mismatch, misalignment, an illegal sector number or a write-protected sector. A refused command produces no request.

Register word offsets are 0x0 for key, 0x4 for control and 0x8 for status, all with the top address bit at 0. With the top address bit at 1, the low address bits are a byte offset into the flash array.

Top module: `flash_cmd_ctrl`

## Requirements
- R1: After reset, a control read returns 0x8000_0000 (locked), a status read returns 0, and no flash request is issued.
- R2: Writing 0x45670123 to the key register, with 0xCDEF89AB as the next key-register write, unlocks the control register: control bit 31 then reads 0. The same sequence unlocks again after a relock.
- R3: A wrong first key, or a wrong second key, keeps the block locked until reset, even if a correct sequence follows.
- R4: Control writes have no effect while locked. An unlocked control write with bit 31 set relocks, clears every control field and ignores the other bits of that write.
- R5: Control fields read back as written: bit 0 program, bit 1 sector erase, bit 2 mass erase, bits 6:3 sector number, bits 9:8 program width (0 byte, 1 halfword, 2 word, 3 doubleword), bit 31 lock. The start bit, bit 16, always reads 0.
- R6: An unlocked control write with bit 16 set and a legal erase selection produces a single one-cycle request. The request op code is 1 for program, 2 for sector erase and 3 for mass erase. For a sector erase the request carries the written sector number. Mass erase wins when both erase bits are set.
- R7: A start with sector erase and a sector number above 11 sets operation-error status bit 1 and issues no request.
- R8: Status bit 16 reads 1 from the cycle after a launch until the macro's busy has risen and fallen again.
- R9: Any of the following sets sequence-error status bit 7 and issues no request: a start while busy, a start with neither erase bit set, or a flash-window write while busy, locked or with the program bit clear.
- R10: A flash-window write is accepted when its size code (0 to 3 for 1, 2, 4 or 8 bytes) equals the control width and the address is aligned. It issues a program request carrying the offset, the data and the size.
- R11: A size mismatch sets parallelism-error bit 6. A misaligned address sets alignment-error bit 5. Only the highest-priority error is flagged, in the order sequence, parallelism, alignment, protection.
- R12: A sector erase or program that hits a sector marked in the write-protect input sets protection-error bit 4 and issues no request. A mass erase does the same when any sector is protected. Sectors 0-3 are 16 KB, sector 4 is 64 KB and sectors 5-11 are 128 KB.
- R13: Writing the status register clears each error flag written with 1 and keeps each flag written with 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_wr | input | 1 | Bus write strobe |
| bus_rd | input | 1 | Bus read strobe |
| bus_addr | input | FOFF_W+1 | Top bit selects the flash window; otherwise bits 3:2 select the register |
| bus_size | input | 2 | Access size code for flash-window writes |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid the cycle after bus_rd |
| wp_sect | input | NUM_SECT | Per-sector write-protect flags |
| fl_busy | input | 1 | Macro busy level |
| fl_req | output | 1 | One-cycle operation request |
| fl_op | output | 2 | Request op code |
| fl_sector | output | SNB_W | Sector of the request |
| fl_addr | output | FOFF_W | Flash byte offset of a program request |
| fl_wdata | output | 32 | Program data |
| fl_size | output | 2 | Program size code |

## Verification
A lock state that has drifted shows up at the next control read as a wrong bit 31. It also shows as a request that appears, or fails to appear, on the edge after a start write. A busy tracker that drops too early lets a second request out while the macro is still busy. One that sticks turns every later command into a sequence error at the next status read. A wrong sector decode or a wrong error priority shows as the wrong status bit one cycle after the offending write.

// File: rtl/fcc_pkg.sv
package fcc_pkg;
  localparam int BUS_W = 32;

  typedef enum logic [1:0] {
    OP_NONE   = 2'd0,
    OP_PROG   = 2'd1,
    OP_SERASE = 2'd2,
    OP_MERASE = 2'd3
  } fl_op_e;

  typedef enum logic [1:0] {
    KS_LOCKED = 2'd0,
    KS_HALF   = 2'd1,
    KS_OPEN   = 2'd2,
    KS_DEAD   = 2'd3
  } key_st_e;

  typedef struct packed {
    logic seq;
    logic par;
    logic aln;
    logic wrp;
    logic ope;
  } err_t;

  // control register bit positions
  localparam int CB_PROG    = 0;
  localparam int CB_SER     = 1;
  localparam int CB_MER     = 2;
  localparam int CB_SNB_LSB = 3;
  localparam int CB_SZ_LSB  = 8;
  localparam int CB_START   = 16;
  localparam int CB_LOCK    = 31;

  // status register bit positions
  localparam int SB_BUSY = 16;
  localparam int SB_SEQ  = 7;
  localparam int SB_PAR  = 6;
  localparam int SB_ALN  = 5;
  localparam int SB_WRP  = 4;
  localparam int SB_OPE  = 1;

  // register word index (address bits 3:2)
  localparam logic [1:0] RI_KEY = 2'd0;
  localparam logic [1:0] RI_CTL = 2'd1;
  localparam logic [1:0] RI_STS = 2'd2;
endpackage

// File: rtl/fcc_key_fsm.sv
module fcc_key_fsm
  import fcc_pkg::*;
#(
  parameter logic [31:0] KEY_A = 32'h4567_0123,
  parameter logic [31:0] KEY_B = 32'hCDEF_89AB
) (
  input  logic        clk,
  input  logic        rst,
  input  logic        key_wr,
  input  logic [31:0] key_val,
  input  logic        relock,
  output key_st_e     state_o
);
  key_st_e st;

  always_ff @(posedge clk) begin
    if (rst) begin
      st <= KS_LOCKED;
    end else begin
      case (st)
        KS_LOCKED: if (key_wr) st <= (key_val == KEY_A) ? KS_HALF : KS_DEAD;
        KS_HALF:   if (key_wr) st <= (key_val == KEY_B) ? KS_OPEN : KS_DEAD;
        KS_OPEN:   if (relock) st <= KS_LOCKED;
        default:   st <= KS_DEAD;
      endcase
    end
  end

  assign state_o = st;
endmodule

// File: rtl/fcc_busy_track.sv
module fcc_busy_track (
  input  logic clk,
  input  logic rst,
  input  logic launch,
  input  logic fl_busy,
  output logic busy_o
);
  logic busy_q;
  logic seen_q;

  // busy covers the gap between the request and the macro's answer
  always_ff @(posedge clk) begin
    if (rst) begin
      busy_q <= 1'b0;
      seen_q <= 1'b0;
    end else if (launch) begin
      busy_q <= 1'b1;
      seen_q <= 1'b0;
    end else if (busy_q) begin
      if (fl_busy) begin
        seen_q <= 1'b1;
      end else if (seen_q) begin
        busy_q <= 1'b0;
        seen_q <= 1'b0;
      end
    end
  end

  assign busy_o = busy_q;
endmodule

// File: rtl/fcc_launch_check.sv
module fcc_launch_check
  import fcc_pkg::*;
#(
  parameter int FOFF_W    = 20,
  parameter int NUM_SECT  = 12,
  parameter int SNB_W     = 4,
  parameter int SMALL_CNT = 4,
  parameter int SMALL_LOG = 14,
  parameter int MID_LOG   = 16,
  parameter int BIG_LOG   = 17
) (
  input  logic              start_wr,
  input  logic              data_wr,
  input  logic              unlocked,
  input  logic              busy,
  input  logic              ser_i,
  input  logic              mer_i,
  input  logic [SNB_W-1:0]  snb_i,
  input  logic              prog_i,
  input  logic [1:0]        psz_i,
  input  logic [1:0]        size_i,
  input  logic [FOFF_W-1:0] off_i,
  input  logic [NUM_SECT-1:0] wp_i,
  output logic              go_o,
  output fl_op_e            op_o,
  output logic [SNB_W-1:0]  sect_o,
  output err_t              err_o
);
  localparam int PAD = 1 << SNB_W;
  localparam logic [31:0] SMALL_END = 32'(SMALL_CNT) << SMALL_LOG;
  localparam logic [31:0] MID_END   = SMALL_END + (32'd1 << MID_LOG);

  logic [PAD-1:0] wp_pad;
  for (genvar g = 0; g < PAD; g++) begin : g_wp
    if (g < NUM_SECT) begin : g_on
      assign wp_pad[g] = wp_i[g];
    end else begin : g_off
      assign wp_pad[g] = 1'b0;
    end
  end

  logic [31:0] off32;
  logic [31:0] sect32;
  logic [SNB_W-1:0] addr_sect;
  logic aln_bad;
  logic snb_ok;

  assign off32 = 32'(off_i);

  always_comb begin
    if (off32 < SMALL_END)    sect32 = off32 >> SMALL_LOG;
    else if (off32 < MID_END) sect32 = 32'(SMALL_CNT);
    else                      sect32 = 32'(SMALL_CNT) + 32'd1 + ((off32 - MID_END) >> BIG_LOG);
  end
  assign addr_sect = SNB_W'(sect32);

  always_comb begin
    case (psz_i)
      2'd0:    aln_bad = 1'b0;
      2'd1:    aln_bad = off_i[0];
      2'd2:    aln_bad = |off_i[1:0];
      default: aln_bad = |off_i[2:0];
    endcase
  end

  assign snb_ok = 32'(snb_i) < NUM_SECT;

  always_comb begin
    go_o   = 1'b0;
    op_o   = OP_NONE;
    sect_o = snb_i;
    err_o  = '0;
    if (start_wr) begin
      if (busy || !(ser_i || mer_i)) begin
        err_o.seq = 1'b1;
      end else if (mer_i) begin
        if (|wp_i) err_o.wrp = 1'b1;
        else begin
          go_o = 1'b1;
          op_o = OP_MERASE;
        end
      end else if (!snb_ok) begin
        err_o.ope = 1'b1;
      end else if (wp_pad[snb_i]) begin
        err_o.wrp = 1'b1;
      end else begin
        go_o = 1'b1;
        op_o = OP_SERASE;
      end
    end else if (data_wr) begin
      sect_o = addr_sect;
      if (!unlocked || !prog_i || busy) begin
        err_o.seq = 1'b1;
      end else if (size_i != psz_i) begin
        err_o.par = 1'b1;
      end else if (aln_bad) begin
        err_o.aln = 1'b1;
      end else if (wp_pad[addr_sect]) begin
        err_o.wrp = 1'b1;
      end else begin
        go_o = 1'b1;
        op_o = OP_PROG;
      end
    end
  end
endmodule

// File: rtl/flash_cmd_ctrl.sv
module flash_cmd_ctrl
  import fcc_pkg::*;
#(
  parameter int FOFF_W    = 20,
  parameter int NUM_SECT  = 12,
  parameter int SNB_W     = 4,
  parameter int SMALL_CNT = 4,
  parameter int SMALL_LOG = 14,
  parameter int MID_LOG   = 16,
  parameter int BIG_LOG   = 17,
  parameter logic [31:0] KEY_A = 32'h4567_0123,
  parameter logic [31:0] KEY_B = 32'hCDEF_89AB
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                bus_wr,
  input  logic                bus_rd,
  input  logic [FOFF_W:0]     bus_addr,
  input  logic [1:0]          bus_size,
  input  logic [BUS_W-1:0]    bus_wdata,
  output logic [BUS_W-1:0]    bus_rdata,
  input  logic [NUM_SECT-1:0] wp_sect,
  input  logic                fl_busy,
  output logic                fl_req,
  output logic [1:0]          fl_op,
  output logic [SNB_W-1:0]    fl_sector,
  output logic [FOFF_W-1:0]   fl_addr,
  output logic [BUS_W-1:0]    fl_wdata,
  output logic [1:0]          fl_size
);
  localparam int ADDR_W = FOFF_W + 1;

  // decode
  logic in_flash;
  logic [1:0] ridx;
  logic key_wr, ctl_wr, sts_wr, data_wr;
  assign in_flash = bus_addr[ADDR_W-1];
  assign ridx     = bus_addr[3:2];
  assign key_wr   = bus_wr && !in_flash && (ridx == RI_KEY);
  assign ctl_wr   = bus_wr && !in_flash && (ridx == RI_CTL);
  assign sts_wr   = bus_wr && !in_flash && (ridx == RI_STS);
  assign data_wr  = bus_wr && in_flash;

  // lock
  key_st_e key_state;
  logic unlocked, key_dead, relock, ctl_upd, start_wr;
  assign unlocked = (key_state == KS_OPEN);
  assign key_dead = (key_state == KS_DEAD);
  assign relock   = ctl_wr && unlocked && bus_wdata[CB_LOCK];
  assign ctl_upd  = ctl_wr && unlocked && !bus_wdata[CB_LOCK];
  assign start_wr = ctl_upd && bus_wdata[CB_START];

  fcc_key_fsm #(.KEY_A(KEY_A), .KEY_B(KEY_B)) u_key (
    .clk     (clk),
    .rst     (rst),
    .key_wr  (key_wr),
    .key_val (bus_wdata),
    .relock  (relock),
    .state_o (key_state)
  );

  // control fields
  logic prog_q, ser_q, mer_q;
  logic [SNB_W-1:0] snb_q;
  logic [1:0] psz_q;

  always_ff @(posedge clk) begin
    if (rst || relock) begin
      prog_q <= 1'b0;
      ser_q  <= 1'b0;
      mer_q  <= 1'b0;
      snb_q  <= '0;
      psz_q  <= '0;
    end else if (ctl_upd) begin
      prog_q <= bus_wdata[CB_PROG];
      ser_q  <= bus_wdata[CB_SER];
      mer_q  <= bus_wdata[CB_MER];
      snb_q  <= bus_wdata[CB_SNB_LSB +: SNB_W];
      psz_q  <= bus_wdata[CB_SZ_LSB +: 2];
    end
  end

  // launch decision
  logic busy_q, go;
  fl_op_e go_op;
  logic [SNB_W-1:0] go_sect;
  err_t err_set, err_clr, err_q;

  fcc_launch_check #(
    .FOFF_W(FOFF_W), .NUM_SECT(NUM_SECT), .SNB_W(SNB_W), .SMALL_CNT(SMALL_CNT),
    .SMALL_LOG(SMALL_LOG), .MID_LOG(MID_LOG), .BIG_LOG(BIG_LOG)
  ) u_chk (
    .start_wr (start_wr),
    .data_wr  (data_wr),
    .unlocked (unlocked),
    .busy     (busy_q),
    .ser_i    (bus_wdata[CB_SER]),
    .mer_i    (bus_wdata[CB_MER]),
    .snb_i    (bus_wdata[CB_SNB_LSB +: SNB_W]),
    .prog_i   (prog_q),
    .psz_i    (psz_q),
    .size_i   (bus_size),
    .off_i    (bus_addr[FOFF_W-1:0]),
    .wp_i     (wp_sect),
    .go_o     (go),
    .op_o     (go_op),
    .sect_o   (go_sect),
    .err_o    (err_set)
  );

  fcc_busy_track u_busy (
    .clk     (clk),
    .rst     (rst),
    .launch  (go),
    .fl_busy (fl_busy),
    .busy_o  (busy_q)
  );

  // sticky errors, write one to clear
  always_comb begin
    err_clr = '0;
    if (sts_wr) begin
      err_clr.seq = bus_wdata[SB_SEQ];
      err_clr.par = bus_wdata[SB_PAR];
      err_clr.aln = bus_wdata[SB_ALN];
      err_clr.wrp = bus_wdata[SB_WRP];
      err_clr.ope = bus_wdata[SB_OPE];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) err_q <= '0;
    else     err_q <= (err_q & ~err_clr) | err_set;
  end

  // macro request, registered
  always_ff @(posedge clk) begin
    if (rst) begin
      fl_req    <= 1'b0;
      fl_op     <= OP_NONE;
      fl_sector <= '0;
      fl_addr   <= '0;
      fl_wdata  <= '0;
      fl_size   <= '0;
    end else begin
      fl_req <= go;
      if (go) begin
        fl_op     <= go_op;
        fl_sector <= go_sect;
        fl_addr   <= bus_addr[FOFF_W-1:0];
        fl_wdata  <= bus_wdata;
        fl_size   <= bus_size;
      end
    end
  end

  // read path
  logic [BUS_W-1:0] ctl_view, sts_view;
  always_comb begin
    ctl_view = '0;
    ctl_view[CB_PROG] = prog_q;
    ctl_view[CB_SER]  = ser_q;
    ctl_view[CB_MER]  = mer_q;
    ctl_view[CB_SNB_LSB +: SNB_W] = snb_q;
    ctl_view[CB_SZ_LSB +: 2] = psz_q;
    ctl_view[CB_LOCK] = !unlocked;
    sts_view = '0;
    sts_view[SB_BUSY] = busy_q;
    sts_view[SB_SEQ]  = err_q.seq;
    sts_view[SB_PAR]  = err_q.par;
    sts_view[SB_ALN]  = err_q.aln;
    sts_view[SB_WRP]  = err_q.wrp;
    sts_view[SB_OPE]  = err_q.ope;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      bus_rdata <= '0;
    end else if (bus_rd) begin
      if (in_flash)              bus_rdata <= '0;
      else if (ridx == RI_CTL)   bus_rdata <= ctl_view;
      else if (ridx == RI_STS)   bus_rdata <= sts_view;
      else                       bus_rdata <= '0;
    end
  end
endmodule

// File: rtl/fcc_sva.sv
module fcc_sva #(
  parameter int FOFF_W   = 20,
  parameter int NUM_SECT = 12,
  parameter int SNB_W    = 4
) (
  input logic             clk,
  input logic             rst,
  input logic             bus_wr,
  input logic [FOFF_W:0]  bus_addr,
  input logic             fl_req,
  input logic [1:0]       fl_op,
  input logic [SNB_W-1:0] fl_sector,
  input logic             fl_busy,
  input logic             busy_q,
  input logic             unlocked,
  input logic             key_dead,
  input logic [4:0]       err_q
);
  logic sts_wr_c;
  assign sts_wr_c = bus_wr && !bus_addr[FOFF_W] && (bus_addr[3:2] == 2'd2);

  AST_REQ_ONE_CYCLE: assert property (@(posedge clk) disable iff (rst)
    fl_req |=> !fl_req);  // R6

  AST_SECTOR_LEGAL: assert property (@(posedge clk) disable iff (rst)
    (fl_req && fl_op == 2'd2) |-> (32'(fl_sector) < NUM_SECT));  // R7

  AST_REQ_WHEN_OPEN: assert property (@(posedge clk) disable iff (rst)
    fl_req |-> $past(unlocked));  // R4

  AST_REQ_NEEDS_IDLE: assert property (@(posedge clk) disable iff (rst)
    fl_req |-> !$past(busy_q));  // R9

  AST_BUSY_COVERS: assert property (@(posedge clk) disable iff (rst)
    fl_busy |-> busy_q);  // R8

  AST_DEAD_STICKS: assert property (@(posedge clk) disable iff (rst)
    key_dead |=> key_dead);  // R3

  AST_ERR_W1C: assert property (@(posedge clk) disable iff (rst)
    (|($past(err_q) & ~err_q)) |-> $past(sts_wr_c));  // R13
endmodule

bind flash_cmd_ctrl fcc_sva #(.FOFF_W(FOFF_W), .NUM_SECT(NUM_SECT), .SNB_W(SNB_W)) u_sva (
  .clk       (clk),
  .rst       (rst),
  .bus_wr    (bus_wr),
  .bus_addr  (bus_addr),
  .fl_req    (fl_req),
  .fl_op     (fl_op),
  .fl_sector (fl_sector),
  .fl_busy   (fl_busy),
  .busy_q    (busy_q),
  .unlocked  (unlocked),
  .key_dead  (key_dead),
  .err_q     (err_q)
);

// File: tb/tb_flash_cmd_ctrl.sv
module tb_flash_cmd_ctrl;
  localparam int CLK_PERIOD = 10;
  localparam int FOFF_W = 20;
  localparam int NUM_SECT = 12;
  localparam int SNB_W = 4;
  localparam int STUB_LAT = 12;
  localparam logic [FOFF_W:0] A_KEY = 21'h0;
  localparam logic [FOFF_W:0] A_CTL = 21'h4;
  localparam logic [FOFF_W:0] A_STS = 21'h8;
  localparam logic [FOFF_W:0] A_FL  = 21'h100000;
  localparam logic [31:0] K1 = 32'h4567_0123;
  localparam logic [31:0] K2 = 32'hCDEF_89AB;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic bus_wr = 1'b0, bus_rd = 1'b0;
  logic [FOFF_W:0] bus_addr = '0;
  logic [1:0] bus_size = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic [NUM_SECT-1:0] wp_sect = '0;
  logic fl_busy;
  logic fl_req;
  logic [1:0] fl_op;
  logic [SNB_W-1:0] fl_sector;
  logic [FOFF_W-1:0] fl_addr;
  logic [31:0] fl_wdata;
  logic [1:0] fl_size;

  int n_checks = 0;
  int n_fail = 0;

  flash_cmd_ctrl dut (
    .clk(clk), .rst(rst), .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_addr(bus_addr),
    .bus_size(bus_size), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .wp_sect(wp_sect),
    .fl_busy(fl_busy), .fl_req(fl_req), .fl_op(fl_op), .fl_sector(fl_sector),
    .fl_addr(fl_addr), .fl_wdata(fl_wdata), .fl_size(fl_size)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  // behavioural macro stub
  int stub_cnt = 0;
  always @(posedge clk) begin
    if (rst) stub_cnt <= 0;
    else if (fl_req) stub_cnt <= STUB_LAT;
    else if (stub_cnt > 0) stub_cnt <= stub_cnt - 1;
  end
  assign fl_busy = (stub_cnt != 0);

  // request capture
  int req_cnt = 0;
  logic [1:0] c_op = '0;
  logic [SNB_W-1:0] c_sect = '0;
  logic [FOFF_W-1:0] c_addr = '0;
  logic [31:0] c_data = '0;
  logic [1:0] c_size = '0;
  always @(posedge clk) begin
    if (!rst && fl_req) begin
      req_cnt <= req_cnt + 1;
      c_op <= fl_op; c_sect <= fl_sector; c_addr <= fl_addr;
      c_data <= fl_wdata; c_size <= fl_size;
    end
  end

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual 0x%08h expected 0x%08h", tag, act, exp);
    end
  endtask

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(input logic [FOFF_W:0] a, input logic [31:0] d, input logic [1:0] sz = 2'd2);
    @(negedge clk);
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d; bus_size = sz;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [FOFF_W:0] a, output logic [31:0] d);
    @(negedge clk);
    bus_rd = 1'b1; bus_addr = a;
    @(negedge clk);
    bus_rd = 1'b0;
    d = bus_rdata;
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst = 1'b1; bus_wr = 1'b0; bus_rd = 1'b0; wp_sect = '0;
    tick(3);
    rst = 1'b0;
    tick(1);
  endtask

  task automatic unlock();
    wr(A_KEY, K1);
    wr(A_KEY, K2);
  endtask

  task automatic wait_idle();
    logic [31:0] s;
    for (int i = 0; i < 60; i++) begin
      rd(A_STS, s);
      if (!s[16]) break;
    end
    tick(1);
  endtask

  task automatic t_reset();
    logic [31:0] v;
    do_reset();
    rd(A_CTL, v); chk("R1 ctrl after reset", v, 32'h8000_0000);
    rd(A_STS, v); chk("R1 status after reset", v, 32'h0);
    chk("R1 no request", 32'(req_cnt), 32'd0);
  endtask

  task automatic t_unlock();
    logic [31:0] v;
    do_reset();
    unlock();
    rd(A_CTL, v); chk("R2 unlocked", v, 32'h0);
    wr(A_CTL, 32'h0000_0229);
    rd(A_CTL, v); chk("R5 field readback", v, 32'h0000_0229);
  endtask

  task automatic t_bad_key();
    logic [31:0] v;
    do_reset();
    wr(A_KEY, K2);
    unlock();
    rd(A_CTL, v); chk("R3 wrong order stays locked", v, 32'h8000_0000);
    wr(A_CTL, 32'h0000_0001);
    rd(A_CTL, v); chk("R4 locked write ignored", v, 32'h8000_0000);
    do_reset();
    wr(A_KEY, K1);
    wr(A_KEY, 32'h1234_5678);
    unlock();
    rd(A_CTL, v); chk("R3 wrong second key stays locked", v, 32'h8000_0000);
  endtask

  task automatic t_relock();
    logic [31:0] v;
    do_reset();
    unlock();
    wr(A_CTL, 32'h0000_0201);
    wr(A_CTL, 32'h8000_0001);
    rd(A_CTL, v); chk("R4 relock clears fields", v, 32'h8000_0000);
    wr(A_CTL, 32'h0000_0002);
    rd(A_CTL, v); chk("R4 write after relock ignored", v, 32'h8000_0000);
    wr(A_FL, 32'h55, 2'd0);
    rd(A_STS, v); chk("R9 data write while locked", v, 32'h0000_0080);
    wr(A_STS, 32'h0000_0080);
    rd(A_STS, v); chk("R13 seq cleared", v, 32'h0);
    unlock();
    rd(A_CTL, v); chk("R2 unlock again after relock", v, 32'h0);
  endtask

  task automatic t_erase();
    logic [31:0] v;
    int base;
    do_reset();
    unlock();
    base = req_cnt;
    wr(A_CTL, 32'h0001_003A);
    tick(1);
    chk("R6 one request", 32'(req_cnt - base), 32'd1);
    chk("R6 sector erase op", {30'd0, c_op}, 32'd2);
    chk("R6 sector number", {28'd0, c_sect}, 32'd7);
    rd(A_STS, v); chk("R8 busy after launch", v, 32'h0001_0000);
    rd(A_CTL, v); chk("R5 start reads zero", v, 32'h0000_003A);
    wait_idle();
    rd(A_STS, v); chk("R8 busy drops", v, 32'h0);
    chk("R6 single pulse", 32'(req_cnt - base), 32'd1);
    wr(A_CTL, 32'h0001_0006);
    tick(1);
    chk("R6 mass erase precedence", {30'd0, c_op}, 32'd3);
    wait_idle();
  endtask

  task automatic t_bad_sector();
    logic [31:0] v;
    int base;
    do_reset();
    unlock();
    base = req_cnt;
    wr(A_CTL, 32'h0001_0062);
    tick(2);
    rd(A_STS, v); chk("R7 sector 12 rejected", v, 32'h0000_0002);
    chk("R7 no request", 32'(req_cnt - base), 32'd0);
    wr(A_STS, 32'h2);
    wr(A_CTL, 32'h0001_005A);
    tick(1);
    chk("R7 sector 11 accepted", {28'd0, c_sect}, 32'd11);
    wait_idle();
  endtask

  task automatic t_busy_seq();
    logic [31:0] v;
    int base;
    do_reset();
    unlock();
    base = req_cnt;
    wr(A_CTL, 32'h0001_003A);
    wr(A_CTL, 32'h0001_0012);
    rd(A_STS, v); chk("R9 start while busy", v, 32'h0001_0080);
    wr(A_STS, 32'h80);
    wr(A_CTL, 32'h0000_0201);
    wr(A_FL, 32'h1, 2'd2);
    rd(A_STS, v); chk("R9 data write while busy", v, 32'h0001_0080);
    chk("R9 only first launched", 32'(req_cnt - base), 32'd1);
    wait_idle();
    wr(A_STS, 32'h80);
    wr(A_CTL, 32'h0001_0000);
    rd(A_STS, v); chk("R9 start without erase select", v, 32'h0000_0080);
    wr(A_STS, 32'h80);
  endtask

  task automatic t_program();
    int base;
    do_reset();
    unlock();
    wr(A_CTL, 32'h0000_0101);
    base = req_cnt;
    wr(A_FL | 21'h0000C2, 32'h0000_BEEF, 2'd1);
    tick(1);
    chk("R10 program launched", 32'(req_cnt - base), 32'd1);
    chk("R10 op program", {30'd0, c_op}, 32'd1);
    chk("R10 address", {12'd0, c_addr}, 32'h0000_00C2);
    chk("R10 data", c_data, 32'h0000_BEEF);
    chk("R10 size", {30'd0, c_size}, 32'd1);
    wait_idle();
    wr(A_CTL, 32'h0000_0301);
    wr(A_FL | 21'h020008, 32'h1234_5678, 2'd3);
    tick(1);
    chk("R10 doubleword size", {30'd0, c_size}, 32'd3);
    chk("R10 doubleword addr", {12'd0, c_addr}, 32'h0002_0008);
    wait_idle();
  endtask

  task automatic t_prog_err();
    logic [31:0] v;
    int base;
    do_reset();
    unlock();
    wr(A_CTL, 32'h0000_0201);
    base = req_cnt;
    wr(A_FL | 21'h10, 32'h0, 2'd1);
    rd(A_STS, v); chk("R11 size mismatch", v, 32'h0000_0040);
    wr(A_STS, 32'h40);
    wr(A_FL | 21'h6, 32'h0, 2'd2);
    rd(A_STS, v); chk("R11 misaligned", v, 32'h0000_0020);
    wr(A_STS, 32'h20);
    wr(A_FL | 21'h3, 32'h0, 2'd1);
    rd(A_STS, v); chk("R11 mismatch beats misalign", v, 32'h0000_0040);
    wr(A_STS, 32'h40);
    wr(A_CTL, 32'h0000_0200);
    wr(A_FL | 21'h4, 32'h0, 2'd2);
    rd(A_STS, v); chk("R9 program bit clear", v, 32'h0000_0080);
    wr(A_STS, 32'h80);
    chk("R11 no requests", 32'(req_cnt - base), 32'd0);
  endtask

  task automatic t_wp();
    logic [31:0] v;
    int base;
    do_reset();
    unlock();
    wp_sect = 12'h020;
    base = req_cnt;
    wr(A_CTL, 32'h0001_002A);
    rd(A_STS, v); chk("R12 protected erase", v, 32'h0000_0010);
    chk("R12 no request", 32'(req_cnt - base), 32'd0);
    wr(A_STS, 32'h10);
    wr(A_CTL, 32'h0001_0022);
    tick(1);
    chk("R12 neighbour sector erased", {28'd0, c_sect}, 32'd4);
    wait_idle();
    wr(A_CTL, 32'h0000_0201);
    base = req_cnt;
    wr(A_FL | 21'h020000, 32'h0, 2'd2);
    rd(A_STS, v); chk("R12 protected program", v, 32'h0000_0010);
    chk("R12 no program request", 32'(req_cnt - base), 32'd0);
    wr(A_STS, 32'h10);
    wr(A_FL | 21'h040000, 32'h0, 2'd2);
    tick(1);
    chk("R12 program sector 6", {28'd0, c_sect}, 32'd6);
    wait_idle();
    wr(A_CTL, 32'h0001_0004);
    rd(A_STS, v); chk("R12 mass erase blocked", v, 32'h0000_0010);
    wr(A_STS, 32'h10);
    wp_sect = '0;
  endtask

  task automatic t_w1c();
    logic [31:0] v;
    do_reset();
    unlock();
    wr(A_CTL, 32'h0000_0201);
    wr(A_FL, 32'h0, 2'd0);
    wr(A_CTL, 32'h0000_0000);
    wr(A_FL, 32'h0, 2'd2);
    rd(A_STS, v); chk("R13 two flags set", v, 32'h0000_00C0);
    wr(A_STS, 32'h0000_0040);
    rd(A_STS, v); chk("R13 clear one flag", v, 32'h0000_0080);
    wr(A_STS, 32'h0000_0000);
    rd(A_STS, v); chk("R13 zero keeps flag", v, 32'h0000_0080);
    wr(A_STS, 32'h0000_0080);
    rd(A_STS, v); chk("R13 all clear", v, 32'h0);
  endtask

  logic done = 1'b0;

  initial begin
    #(CLK_PERIOD * 100000);
    if (!done) begin
      n_checks++;
      n_fail++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
    end
  end

  initial begin
    t_reset();
    t_unlock();
    t_bad_key();
    t_relock();
    t_erase();
    t_bad_sector();
    t_busy_seq();
    t_program();
    t_prog_err();
    t_wp();
    t_w1c();
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end
endmodule